// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clear-to-Send Gating

This block sends 8-bit frames over a clocked serial link and drives the link clock itself. The host writes a byte into a one-entry holding buffer. When transmission is enabled and the far end signals clear-to-send, the byte moves into a shift register on the first active transfer-clock edge. The data bits then leave one per transfer-clock period on the data output. The move from buffer to shift register raises a sticky buffer-empty interrupt request, so the host can queue the next byte while the current one is still shifting.

The half-period of the transfer clock comes from a base prescaler and a programmable divider. The prescaler divides the system clock by 1, 8 or 32. The divider spans 1 to 256. Each bit lasts two half-periods. Option inputs select MSB-first order, data change on the rising pin edge instead of the falling one, and an inverted data line. When no further byte is pending at the end of a frame, the clock parks and the transmit-register-empty flag rises. A byte written before the last bit finishes follows on with no idle time on the clock.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, sclk_o = 1 and txd_o = 1 (with rise_edge = 0 and invert = 0), tx_empty_o = 1, irq_o = 0 and buf_full_o = 0.
- R2: A wr_strobe cycle stores wr_data and sets buf_full_o on the next clock. A frame starts only while tx_en = 1 and the buffer is full. With tx_en = 0, a written byte waits, the clock stays parked and buf_full_o stays 1.
- R3: With cts_en = 1, a frame may start only while cts_n = 0. cts_n is looked at only when a frame starts, so raising it in the middle of a frame does not cut that frame short. With cts_en = 0, cts_n is ignored.
- R4: The clock after the start condition holds, the internal clock falls (sclk_o = 0 in default mode), the first data bit is driven, irq_o = 1, buf_full_o = 0 and tx_empty_o = 0.
- R5: Every transfer-clock half-period lasts N = P * (baud_div + 1) system clocks. P is 1 for clk_sel = 0, 8 for clk_sel = 1, and 32 for clk_sel = 2 or 3.
- R6: By default, bits leave LSB first and each new bit is driven on a falling clock edge. After 8 bits with no byte pending, the clock stays high, txd_o returns to its idle level, and tx_empty_o becomes 1 one half-period after the last rising edge.
- R7: A byte written before the current frame ends is sent straight after it. The falling edge that starts the next frame comes one half-period after the last rising edge, and tx_empty_o stays 0 between the two frames.
- R8: With msb_first = 1, bit 7 leaves first and bit 0 last.
- R9: With rise_edge = 1, sclk_o is the complement of the internal clock. It parks low, and data changes on rising edges of sclk_o.
- R10: With invert = 1, txd_o is the complement of each data bit and of the idle level.
- R11: irq_o stays 1 until an irq_clr pulse clears it. If a buffer load and irq_clr fall in the same cycle, irq_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable |
| clk_sel | input | 2 | Prescaler select: 0 /1, 1 /8, 2 or 3 /32 |
| baud_div | input | 8 | Extra divider minus one (1 to 256) |
| msb_first | input | 1 | Send bit 7 first |
| rise_edge | input | 1 | Drive data on the rising pin edge (clock parks low) |
| invert | input | 1 | Invert the data line |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send from the receiver, low active |
| wr_strobe | input | 1 | Write wr_data into the holding buffer |
| wr_data | input | 8 | Byte to send |
| irq_clr | input | 1 | Clear the interrupt request |
| sclk_o | output | 1 | Transfer clock output |
| txd_o | output | 1 | Serial data output |
| irq_o | output | 1 | Sticky buffer-empty interrupt request |
| tx_empty_o | output | 1 | Shift register empty |
| buf_full_o | output | 1 | Holding buffer holds a byte |

## Verification
The bench aims at the frame boundary. It writes a second byte while the first is still shifting and requires an unbroken clock. A design that waited for idle, or re-sampled clear-to-send, would show a long high gap and a pulse on the empty flag. Clear-to-send is held off across a write and then raised in the middle of a frame. A design that gates on a level would either start early or truncate the frame, and the byte comparison catches both. Every half-period is timed under several prescaler and divider settings, so an off-by-one in the tick counter shows up as a wrong interval. The MSB-first, rising-edge and inverted-line options are each run with a byte that is not a palindrome, which exposes swapped bit order and wrong idle levels.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  typedef enum logic [1:0] {
    SEL_DIV1  = 2'd0,
    SEL_DIV8  = 2'd1,
    SEL_DIV32 = 2'd2,
    SEL_DIV32B = 2'd3
  } ssx_sel_e;

  // base prescale factor for a clock-select code
  function automatic int unsigned presc_of(input logic [1:0] sel);
    case (sel)
      SEL_DIV1: return 1;
      SEL_DIV8: return 8;
      default:  return 32;
    endcase
  endfunction

  // system clocks per transfer-clock half period
  function automatic int unsigned half_len(input logic [1:0] sel,
                                           input int unsigned div_m1);
    return presc_of(sel) * (div_m1 + 1);
  endfunction

endpackage

// File: rtl/ssx_tick_gen.sv
module ssx_tick_gen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       clk_sel,
  input  logic [DIV_W-1:0] baud_div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(ssx_pkg::half_len(clk_sel, 32'(baud_div)));
  assign tick  = run && (cnt_q >= limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R5: a half period never ends before its counter has started from zero
  assert_tick_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> cnt_q == '0);
endmodule

// File: rtl/ssx_txbuf.sv
module ssx_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic [DATA_W-1:0] data,
  output logic              full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else if (wr) begin
      data <= wdata;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assert_take_needs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);
  assert_take_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr) |=> !full);
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ready,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              msb_first,
  output logic              load,
  output logic              frame_end,
  output logic              busy,
  output logic              sclk_int,
  output logic              txd_int
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [BIT_W-1:0]  bit_nxt;
  logic              busy_q, sclk_q, txd_q;
  logic              at_last, tail_tick;

  function automatic logic pick_bit(input logic [DATA_W-1:0] v,
                                    input logic [BIT_W-1:0] idx,
                                    input logic msb);
    return msb ? v[LAST - idx] : v[idx];
  endfunction

  assign at_last   = (bitcnt_q == LAST);
  assign tail_tick = busy_q && tick && sclk_q && at_last;
  assign load      = ready && (!busy_q || tail_tick);
  assign frame_end = tail_tick && !ready;
  assign bit_nxt   = bitcnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      bitcnt_q <= '0;
      busy_q   <= 1'b0;
      sclk_q   <= 1'b1;
      txd_q    <= 1'b1;
    end else if (load) begin
      shreg_q  <= buf_data;
      bitcnt_q <= '0;
      busy_q   <= 1'b1;
      sclk_q   <= 1'b0;
      txd_q    <= pick_bit(buf_data, '0, msb_first);
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else if (at_last) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else begin
        bitcnt_q <= bit_nxt;
        sclk_q   <= 1'b0;
        txd_q    <= pick_bit(shreg_q, bit_nxt, msb_first);
      end
    end
  end

  assign busy     = busy_q;
  assign sclk_int = sclk_q;
  assign txd_int  = txd_q;

  assert_idle_clock_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sclk_q);
  assert_load_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !sclk_q && bitcnt_q == '0));
  assert_clock_still_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(sclk_q));
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [1:0]        clk_sel,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              msb_first,
  input  logic              rise_edge,
  input  logic              invert,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic              sclk_o,
  output logic              txd_o,
  output logic              irq_o,
  output logic              tx_empty_o,
  output logic              buf_full_o
);
  localparam int CNT_W = $clog2(32 * (2 ** DIV_W)) + 1;

  logic [DATA_W-1:0] buf_data;
  logic buf_full, ready, cts_ok;
  logic load, frame_end, busy, tick, sclk_int, txd_int;
  logic irq_q, empty_q;

  assign cts_ok = !cts_en || !cts_n;
  assign ready  = tx_en && buf_full && cts_ok;

  ssx_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr(wr_strobe), .wdata(wr_data),
    .take(load), .data(buf_data), .full(buf_full)
  );

  ssx_tick_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .clk_sel(clk_sel),
    .baud_div(baud_div), .tick(tick)
  );

  ssx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ready(ready),
    .buf_data(buf_data), .msb_first(msb_first), .load(load),
    .frame_end(frame_end), .busy(busy), .sclk_int(sclk_int), .txd_int(txd_int)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (load)         irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (load)           empty_q <= 1'b0;
      else if (frame_end) empty_q <= 1'b1;
    end
  end

  assign sclk_o     = sclk_int ^ rise_edge;
  assign txd_o      = txd_int ^ invert;
  assign irq_o      = irq_q;
  assign tx_empty_o = empty_q;
  assign buf_full_o = buf_full;

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (tx_en && buf_full));
  assert_cts_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cts_en) |-> !cts_n);
  assert_irq_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (irq_q && !empty_q));
  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  assert_empty_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (empty_q && !busy));
endmodule

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, msb_first = 1'b0, rise_edge = 1'b0, invert = 1'b0;
  logic cts_en = 1'b0, cts_n = 1'b1, wr_strobe = 1'b0, irq_clr = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] baud_div = 8'd0, wr_data = 8'd0;
  logic sclk_o, txd_o, irq_o, tx_empty_o, buf_full_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ser_tx i_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .clk_sel(clk_sel),
    .baud_div(baud_div), .msb_first(msb_first), .rise_edge(rise_edge),
    .invert(invert), .cts_en(cts_en), .cts_n(cts_n), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .irq_clr(irq_clr), .sclk_o(sclk_o), .txd_o(txd_o),
    .irq_o(irq_o), .tx_empty_o(tx_empty_o), .buf_full_o(buf_full_o)
  );

  function automatic int exp_half();
    int p;
    p = (clk_sel == 2'd0) ? 1 : (clk_sel == 2'd1) ? 8 : 32;
    return p * (int'(baud_div) + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: write a byte and queue it as expected
  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_strobe = 1'b1;
    wr_data   = d;
    exp_q.push_back(d);
    @(negedge clk);
    wr_strobe = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!(exp_q.size() == 0 && tx_empty_o) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(n < 20000, req, n, 20000);
  endtask

  // monitor: rebuild frames at the pin and time each half period
  logic prev_pin = 1'b1;
  int   nbits = 0, since = 0;
  bit   have_prev = 1'b0;
  logic [7:0] frame = 8'd0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pin = sclk_o; nbits = 0; since = 0; have_prev = 0;
    end else begin
      logic smp_lvl, b;
      since++;
      if (tx_empty_o) begin
        have_prev = 0;
        nbits = 0;
      end
      if (sclk_o != prev_pin && !tx_empty_o) begin
        if (have_prev)
          check(since == exp_half(), "R5/R7 half period", since, exp_half());
        have_prev = 1;
        smp_lvl = rise_edge ? 1'b0 : 1'b1;
        if (sclk_o == smp_lvl) begin
          b = txd_o ^ invert;
          frame = msb_first ? {frame[6:0], b} : {b, frame[7:1]};
          nbits++;
          if (nbits == 8) begin
            nbits = 0;
            if (exp_q.size() == 0)
              check(0, "R2 unexpected frame", frame, -1);
            else
              check(frame == exp_q[0], "R6/R8 frame data", frame, exp_q[0]);
            if (exp_q.size() != 0) void'(exp_q.pop_front());
          end
        end
      end
      if (sclk_o != prev_pin) since = 0;
      prev_pin = sclk_o;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      check(0, "watchdog", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit gap;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclk_o == 1, "R1 sclk", sclk_o, 1);
    check(txd_o == 1, "R1 txd", txd_o, 1);
    check(tx_empty_o == 1, "R1 tx_empty", tx_empty_o, 1);
    check(irq_o == 0 && buf_full_o == 0, "R1 irq/buf", irq_o + 2*buf_full_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled transmitter holds the byte
    send(8'hA5);
    repeat (40) @(negedge clk);
    check(sclk_o == 1 && tx_empty_o == 1, "R2 no start when disabled", sclk_o, 1);
    check(buf_full_o == 1, "R2 buffer full", buf_full_o, 1);
    tx_en = 1'b1;
    @(negedge clk);
    // R4: load happened on the edge after enable
    check(sclk_o == 0 && txd_o == 1, "R4 first fall, bit0 of A5", {sclk_o, txd_o}, 1);
    check(irq_o == 1 && buf_full_o == 0 && tx_empty_o == 0, "R4 flags",
          {irq_o, buf_full_o, tx_empty_o}, 4);
    wait_idle("R6 frame end");
    check(sclk_o == 1 && txd_o == 1, "R6 parked levels", {sclk_o, txd_o}, 3);
    // R11 sticky irq then clear
    check(irq_o == 1, "R11 irq sticky", irq_o, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq_o == 0, "R11 irq cleared", irq_o, 0);

    // R4 timing from a write with enable already on
    send(8'h3C);
    @(negedge clk);
    check(sclk_o == 0 && txd_o == 0, "R4 start one clock after write", {sclk_o, txd_o}, 0);
    wait_idle("R6 second frame");

    // R5 with /8 and divider 2 (N = 24)
    clk_sel = 2'd1; baud_div = 8'd2;
    send(8'h81);
    wait_idle("R5 /8 frame");
    // R5 with /32 and divider 1 (N = 64)
    clk_sel = 2'd2; baud_div = 8'd1;
    send(8'h6E);
    wait_idle("R5 /32 frame");
    clk_sel = 2'd0; baud_div = 8'd3;

    // R7 back-to-back without a gap
    send(8'h12);
    while (buf_full_o) @(negedge clk);
    send(8'hF0);
    gap = 0;
    while (exp_q.size() > 0) begin
      @(negedge clk);
      if (tx_empty_o) gap = 1;
    end
    check(!gap, "R7 no empty gap between frames", gap, 0);
    wait_idle("R7 end");

    // R3 clear-to-send gating
    cts_en = 1'b1; cts_n = 1'b1;
    send(8'hC3);
    repeat (60) @(negedge clk);
    check(sclk_o == 1 && buf_full_o == 1, "R3 held off by cts", {sclk_o, buf_full_o}, 3);
    cts_n = 1'b0;
    repeat (20) @(negedge clk);
    cts_n = 1'b1;   // mid-frame: frame must still complete
    wait_idle("R3 frame completes after cts rises");
    cts_en = 1'b0;  // cts_n still high but ignored
    send(8'h5A);
    wait_idle("R3 cts ignored when disabled");

    // R8 MSB first
    msb_first = 1'b1;
    send(8'h1D);
    wait_idle("R8 msb frame");
    msb_first = 1'b0;

    // R9 rising-edge mode
    rise_edge = 1'b1;
    @(negedge clk);
    check(sclk_o == 0, "R9 parks low", sclk_o, 0);
    send(8'hB4);
    wait_idle("R9 frame");
    check(sclk_o == 0, "R9 parks low after frame", sclk_o, 0);
    rise_edge = 1'b0;

    // R10 inverted data line
    invert = 1'b1;
    @(negedge clk);
    check(txd_o == 0, "R10 idle inverted", txd_o, 0);
    send(8'h2B);
    wait_idle("R10 frame");
    invert = 1'b0;

    // R11 load and clear in the same cycle: set wins
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    @(negedge clk);
    wr_strobe = 1'b1; wr_data = 8'h77; exp_q.push_back(8'h77);
    @(negedge clk);
    wr_strobe = 1'b0; irq_clr = 1'b1;   // load edge coincides with clear
    @(negedge clk);
    irq_clr = 1'b0;
    check(irq_o == 1, "R11 set wins over clear", irq_o, 1);
    wait_idle("R11 frame");

    check(exp_q.size() == 0, "R2 all frames sent", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule